// File: doc/BRIEF.md
# Prescaled Interval Timer with Watchdog Mode

This block is one timer channel on a register bus. A prescale stage divides the clock by a programmed factor, and a period stage counts prescaled ticks down to an expiry. The whole interval is the product of the two factors, up to about 2^32 clocks with the full 16-bit fields. On each expiry the block pulses an event output, latches a status flag and, when enabled, raises an interrupt. The timer runs either once or repeatedly.

When the watchdog bit is set, the same counter becomes a watchdog. Software must write a fixed keepalive byte into the top byte lane of the mode register before the interval runs out. If it does not, the block issues a one-cycle reset request and halts. Once set, the watchdog bit can be cleared only by a reset. A status bit also reports the level of an external pin after a synchronizer.

Top module: `prescaled_wdog_timer`

## Requirements
- R1: Registers sit at word addresses 0 (mode), 1 (count) and 2 (status). The count register holds the prescale factor in bits [16 +: PRESC_W] and the period count in bits [0 +: CNT_W]. Each write lane selected by `bus_be[i]` updates bits [8i+7:8i], and the register reads back as written.
- R2: A write that sets enable (mode bit 12) while it is clear loads both stages. The first expiry pulse on `expire_o` appears exactly P*C clock edges later. P and C are the field values, and a value of 0 stands for 2^PRESC_W or 2^CNT_W.
- R3: With mode bit 10 clear (one-shot), the timer expires once and hardware clears mode bit 12 at that expiry.
- R4: With mode bit 10 set and the watchdog off, expiries repeat every P*C edges, and both stages reload on each expiry.
- R5: Writing mode bit 12 to 0 stops counting, and no further expiry occurs.
- R6: Each expiry sets status bit 0, and a set takes priority over a clear in the same cycle. Writing 1 to status bits 3:0 through lane 0 clears them, and writing 0 leaves them unchanged.
- R7: `irq_o` is high exactly when status bit 0 and mode bit 8 are both set.
- R8: With mode bit 15 set, an expiry drives `wdt_rst_o` high for one cycle and clears mode bit 12, so the counter halts without reloading.
- R9: A write with `bus_be[3]` set and `bus_wdata[31:24]` = 0xA5, made while bits 15 and 12 are both set, reloads both stages. Any other byte value, or the same write with the watchdog off, leaves the countdown untouched.
- R10: Once set, mode bit 15 stays set until reset. While it is set, a write cannot clear mode bit 12.
- R11: Status bit 8 shows `pin_i` delayed by SYNC_STAGES clock edges.
- R12: After reset, all registers read 0 and `expire_o`, `irq_o` and `wdt_rst_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| pin_i | input | 1 | External pin level, asynchronous |
| expire_o | output | 1 | One-cycle pulse per expiry |
| irq_o | output | 1 | Interrupt request, level |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
If a stage counter is off by one, or a terminal test is wrong, the expiry pulse lands on the wrong edge. The bench measures that edge for every prescale and period pair of a 3-bit configuration, so such a fault shows within at most 64 cycles of the enabling write. A lost or doubled reload in continuous mode or after a keepalive shows as a wrong spacing of the next pulse. A sticky-bit or lock fault shows at the next readback of the mode register. A status flag stuck at the wrong value shows on `irq_o` as soon as the interrupt enable is set.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    // Word addresses of the register file.
    localparam logic [1:0] A_MODE  = 2'd0;
    localparam logic [1:0] A_COUNT = 2'd1;
    localparam logic [1:0] A_STAT  = 2'd2;

    // Bit positions in the mode and status words.
    localparam int B_IE   = 8;
    localparam int B_CONT = 10;
    localparam int B_EN   = 12;
    localparam int B_WDE  = 15;
    localparam int B_PIN  = 8;

    // Offset of the prescale field in the count word.
    localparam int PRESC_LSB = 16;

    // Keepalive byte expected in the top write lane.
    localparam logic [7:0] KICK_CODE = 8'hA5;

    typedef struct packed {
        logic wde;
        logic en;
        logic cont;
        logic ie;
    } mode_t;

    typedef struct packed {
        logic load;  // load both stages from the programmed fields
        logic run;   // stages advance
    } stage_ctl_t;

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) begin
            m[8*i +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                               input logic [31:0] new_w,
                                               input logic [3:0]  be);
        logic [31:0] m;
        m = lane_mask(be);
        return (old_w & ~m) | (new_w & m);
    endfunction

    function automatic logic [31:0] mode_word(input mode_t m);
        logic [31:0] w;
        w         = '0;
        w[B_IE]   = m.ie;
        w[B_CONT] = m.cont;
        w[B_EN]   = m.en;
        w[B_WDE]  = m.wde;
        return w;
    endfunction

endpackage

// File: rtl/pwt_stage.sv
module pwt_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] value,
    output logic         terminal
);

    logic [W-1:0] cnt_q;

    // A loaded value N reaches 1 after N-1 steps, so the stage lasts N
    // steps. 0 wraps through all ones and lasts 2^W steps.
    assign terminal = (cnt_q == W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= value;
        end else if (step) begin
            cnt_q <= terminal ? value : cnt_q - W'(1);
        end
    end

endmodule

// File: rtl/pwt_core.sv
module pwt_core
    import pwt_pkg::*;
#(
    parameter int PRESC_W = 16,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  stage_ctl_t         ctl,
    input  logic [PRESC_W-1:0] presc,
    input  logic [CNT_W-1:0]   reload,
    output logic               expire
);

    logic p_term;
    logic c_term;

    pwt_stage #(.W(PRESC_W)) i_presc_stage (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.load),
        .step     (ctl.run),
        .value    (presc),
        .terminal (p_term)
    );

    pwt_stage #(.W(CNT_W)) i_period_stage (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.load),
        .step     (ctl.run & p_term),
        .value    (reload),
        .terminal (c_term)
    );

    // Both stages are at their last tick: this edge ends the interval.
    // Each stage reloads itself here.
    assign expire = ctl.run & p_term & c_term;

endmodule

// File: rtl/pwt_regs.sv
module pwt_regs
    import pwt_pkg::*;
#(
    parameter int PRESC_W     = 16,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               pin_i,
    input  logic               core_expire,
    output mode_t              mode_q,
    output logic [PRESC_W-1:0] presc_q,
    output logic [CNT_W-1:0]   reload_q,
    output logic               flag_q,
    output stage_ctl_t         ctl,
    output logic               expire_q,
    output logic               wdt_req_q
);

    logic        wr_mode;
    logic        wr_count;
    logic        wr_stat;
    logic        lane1;
    logic        kick;
    logic        hw_stop;
    mode_t       mode_d;
    logic [31:0] cnt_word;
    logic [31:0] cnt_new;
    logic [SYNC_STAGES-1:0] sync_q;

    assign wr_mode  = bus_sel & bus_wr & (bus_addr == A_MODE);
    assign wr_count = bus_sel & bus_wr & (bus_addr == A_COUNT);
    assign wr_stat  = bus_sel & bus_wr & (bus_addr == A_STAT);
    assign lane1    = wr_mode & bus_be[1];

    // Expiry halts the counter in one-shot and watchdog operation.
    assign hw_stop  = core_expire & (mode_q.wde | ~mode_q.cont);

    always_comb begin
        mode_d = mode_q;
        if (lane1) begin
            mode_d.ie   = bus_wdata[B_IE];
            mode_d.cont = bus_wdata[B_CONT];
            mode_d.en   = bus_wdata[B_EN] | (mode_q.wde & mode_q.en);
            mode_d.wde  = bus_wdata[B_WDE] | mode_q.wde;
        end
        if (hw_stop) begin
            mode_d.en = 1'b0;
        end
    end

    assign kick = wr_mode & bus_be[3] & (bus_wdata[31:24] == KICK_CODE)
                & mode_q.wde & mode_q.en;

    assign ctl.load = (mode_d.en & ~mode_q.en) | kick;
    assign ctl.run  = mode_q.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Count register with per-lane writes.
    always_comb begin
        cnt_word                       = '0;
        cnt_word[PRESC_LSB +: PRESC_W] = presc_q;
        cnt_word[0 +: CNT_W]           = reload_q;
    end

    assign cnt_new = lane_merge(cnt_word, bus_wdata, bus_be);

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q  <= '0;
            reload_q <= '0;
        end else if (wr_count) begin
            presc_q  <= cnt_new[PRESC_LSB +: PRESC_W];
            reload_q <= cnt_new[0 +: CNT_W];
        end
    end

    // Expiry flag: set has priority over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (core_expire) begin
            flag_q <= 1'b1;
        end else if (wr_stat & bus_be[0] & bus_wdata[0]) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            expire_q  <= 1'b0;
            wdt_req_q <= 1'b0;
        end else begin
            expire_q  <= core_expire;
            wdt_req_q <= core_expire & mode_q.wde;
        end
    end

    // Pin synchronizer chain.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q[g] <= 1'b0;
            end else if (g == 0) begin
                sync_q[g] <= pin_i;
            end else begin
                sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                A_MODE:  bus_rdata = mode_word(mode_q);
                A_COUNT: bus_rdata = cnt_word;
                A_STAT: begin
                    bus_rdata[0]     = flag_q;
                    bus_rdata[B_PIN] = sync_q[SYNC_STAGES-1];
                end
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/prescaled_wdog_timer.sv
module prescaled_wdog_timer
    import pwt_pkg::*;
#(
    parameter int PRESC_W     = 16,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        pin_i,
    output logic        expire_o,
    output logic        irq_o,
    output logic        wdt_rst_o
);

    mode_t              mode_q;
    logic [PRESC_W-1:0] presc_q;
    logic [CNT_W-1:0]   reload_q;
    logic               status_flag;
    stage_ctl_t         ctl;
    logic               core_expire;
    logic               mode_en;
    logic               mode_wde;

    pwt_regs #(
        .PRESC_W     (PRESC_W),
        .CNT_W       (CNT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) i_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_be      (bus_be),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pin_i       (pin_i),
        .core_expire (core_expire),
        .mode_q      (mode_q),
        .presc_q     (presc_q),
        .reload_q    (reload_q),
        .flag_q      (status_flag),
        .ctl         (ctl),
        .expire_q    (expire_o),
        .wdt_req_q   (wdt_rst_o)
    );

    pwt_core #(
        .PRESC_W (PRESC_W),
        .CNT_W   (CNT_W)
    ) i_core (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .presc   (presc_q),
        .reload  (reload_q),
        .expire  (core_expire)
    );

    assign mode_en  = mode_q.en;
    assign mode_wde = mode_q.wde;
    assign irq_o    = status_flag & mode_q.ie;

endmodule

// File: rtl/pwt_checker.sv
module pwt_checker (
    input logic clk,
    input logic rst,
    input logic expire,
    input logic wdt_rst,
    input logic en,
    input logic wde,
    input logic flag
);

    // R6: an expiry always leaves the status flag set
    p_flag_on_expire_r6: assert property (@(posedge clk) disable iff (rst)
        expire |-> flag);

    // R8: a watchdog reset request only arises with the watchdog armed
    p_req_needs_wde_r8: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> wde);

    // R8: the reset request lasts a single cycle
    p_req_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |=> !wdt_rst);

    // R8: the counter is halted when the reset request appears
    p_req_halts_r8: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> !en);

    // R10: watchdog enable never falls outside reset
    p_wde_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        wde |=> wde);

    // R10: an armed watchdog loses enable only through its own expiry
    p_en_locked_r10: assert property (@(posedge clk) disable iff (rst)
        (wde && en) |=> (en || wdt_rst));

endmodule

bind prescaled_wdog_timer pwt_checker i_pwt_checker (
    .clk     (clk),
    .rst     (rst),
    .expire  (expire_o),
    .wdt_rst (wdt_rst_o),
    .en      (mode_en),
    .wde     (mode_wde),
    .flag    (status_flag)
);

// File: tb/test_prescaled_wdog_timer.sv
`timescale 1ns/1ps
module test_prescaled_wdog_timer;

    localparam int PW = 3;
    localparam int CW = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pin_i = 1'b0;
    logic        expire_o;
    logic        irq_o;
    logic        wdt_rst_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    prescaled_wdog_timer #(.PRESC_W(PW), .CNT_W(CW), .SYNC_STAGES(2)) i_prescaled_wdog_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_i     (pin_i),
        .expire_o  (expire_o),
        .irq_o     (irq_o),
        .wdt_rst_o (wdt_rst_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Called at a negedge; crosses exactly one rising edge.
    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
    endtask

    // Combinational read; crosses no edge.
    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Edges until the chosen output is seen high; max+1 when never.
    task automatic wait_evt(input bit use_wdt, input int max, output int k);
        k = max + 1;
        for (int i = 1; i <= max; i++) begin
            @(negedge clk);
            if ((use_wdt ? wdt_rst_o : expire_o) === 1'b1) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R2 actual=0x0 expected=0x1 (run did not finish)");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        int k;
        @(negedge clk);
        do_reset();

        // R12: reset state
        rd_reg(2'd0, d); check("R12 mode after reset", d, 32'h0);
        rd_reg(2'd1, d); check("R12 count after reset", d, 32'h0);
        rd_reg(2'd2, d); check("R12 status after reset", d, 32'h0);
        check("R12 outputs after reset", {29'b0, expire_o, irq_o, wdt_rst_o}, 32'h0);

        // R1: count register fields and lanes
        wr_reg(2'd1, 32'hFFFF_FFFF, 4'hF);
        rd_reg(2'd1, d); check("R1 full write", d, 32'h0007_0007);
        wr_reg(2'd1, 32'h0002_0005, 4'b0001);
        rd_reg(2'd1, d); check("R1 lane0 only", d, 32'h0007_0005);
        wr_reg(2'd1, 32'h0001_0000, 4'b0100);
        rd_reg(2'd1, d); check("R1 lane2 only", d, 32'h0001_0005);

        // R2 R3 R7 R6: one-shot sweep over every prescale/period pair
        for (int p = 0; p < (1 << PW); p++) begin
            for (int c = 0; c < (1 << CW); c++) begin
                int np;
                int nc;
                np = (p == 0) ? (1 << PW) : p;
                nc = (c == 0) ? (1 << CW) : c;
                wr_reg(2'd1, 32'((p << 16) | c), 4'hF);
                wr_reg(2'd0, 32'h0000_1100, 4'b0010);
                wait_evt(1'b0, np * nc + 2, k);
                check($sformatf("R2 period p=%0d c=%0d", p, c), 32'(k), 32'(np * nc));
                check("R7 irq with flag and enable", {31'b0, irq_o}, 32'h1);
                rd_reg(2'd0, d); check("R3 enable cleared by one-shot", d, 32'h0000_0100);
                wr_reg(2'd2, 32'h1, 4'b0001);
                check("R6 irq after clear", {31'b0, irq_o}, 32'h0);
                rd_reg(2'd2, d); check("R6 status after clear", d, 32'h0);
            end
        end
        wait_evt(1'b0, 80, k);
        check("R3 no second one-shot expiry", 32'(k), 32'd81);

        // R4: continuous, P=2 C=3, interrupt disabled
        wr_reg(2'd1, 32'h0002_0003, 4'hF);
        wr_reg(2'd0, 32'h0000_1400, 4'b0010);
        wait_evt(1'b0, 10, k); check("R4 first period", 32'(k), 32'd6);
        wait_evt(1'b0, 10, k); check("R4 second period", 32'(k), 32'd6);
        wait_evt(1'b0, 10, k); check("R4 third period", 32'(k), 32'd6);
        check("R7 no irq with enable off", {31'b0, irq_o}, 32'h0);
        rd_reg(2'd2, d); check("R6 flag set by expiry", d, 32'h1);

        // R9: keepalive ignored while watchdog is off
        tick(2);
        wr_reg(2'd0, 32'hA500_0000, 4'b1000);
        wait_evt(1'b0, 10, k); check("R9 kick ignored without watchdog", 32'(k), 32'd3);

        // R5: stop
        wr_reg(2'd0, 32'h0000_0400, 4'b0010);
        wait_evt(1'b0, 40, k); check("R5 no expiry after stop", 32'(k), 32'd41);
        rd_reg(2'd0, d); check("R5 mode after stop", d, 32'h0000_0400);

        // R7: raising the enable exposes the pending flag
        wr_reg(2'd0, 32'h0000_0100, 4'b0010);
        check("R7 irq follows enable", {31'b0, irq_o}, 32'h1);

        // R6: write-one-to-clear rules
        wr_reg(2'd2, 32'hFFFF_FFFE, 4'hF);
        rd_reg(2'd2, d); check("R6 zero does not clear", d, 32'h1);
        wr_reg(2'd2, 32'h0000_0001, 4'b1110);
        rd_reg(2'd2, d); check("R6 lane0 disabled does not clear", d, 32'h1);
        wr_reg(2'd2, 32'h0000_0001, 4'b0001);
        rd_reg(2'd2, d); check("R6 one clears", d, 32'h0);
        check("R7 irq gone with flag", {31'b0, irq_o}, 32'h0);

        // R11: pin synchronizer latency
        pin_i = 1'b1;
        rd_reg(2'd2, d); check("R11 pin after 0 edges", d, 32'h0);
        tick(1);
        rd_reg(2'd2, d); check("R11 pin after 1 edge", d, 32'h0);
        tick(1);
        rd_reg(2'd2, d); check("R11 pin after 2 edges", d, 32'h100);
        pin_i = 1'b0;

        // R8 R9 R10: watchdog, P=3 C=4 (12 edges)
        do_reset();
        rd_reg(2'd0, d); check("R12 watchdog cleared by reset", d, 32'h0);
        wr_reg(2'd1, 32'h0003_0004, 4'hF);
        wr_reg(2'd0, 32'h0000_9000, 4'b0010);          // edge 0
        wr_reg(2'd0, 32'h0000_0000, 4'b0010);          // edge 1
        rd_reg(2'd0, d); check("R10 clear attempt ignored", d, 32'h0000_9000);
        tick(7);                                        // edge 8
        wr_reg(2'd0, 32'hA500_0000, 4'b1000);          // edge 9: refresh
        tick(2);                                        // edge 11
        wr_reg(2'd0, 32'hA400_0000, 4'b1000);          // edge 12: wrong byte
        wait_evt(1'b1, 20, k);
        check("R9 refresh timing and wrong byte ignored", 32'(k), 32'd9);
        check("R8 expiry pulse with reset request", {31'b0, expire_o}, 32'h1);
        tick(1);
        check("R8 reset request one cycle", {31'b0, wdt_rst_o}, 32'h0);
        rd_reg(2'd0, d); check("R8 halted, R10 watchdog kept", d, 32'h0000_8000);
        wait_evt(1'b1, 40, k); check("R8 no reload after request", 32'(k), 32'd41);

        summary();
        $finish;
    end

endmodule